// File: doc/BRIEF.md
# Oscillator Configuration Register Slave with Nonvolatile Commit

This block is a two-wire serial slave that holds the configuration registers of a programmable clock source: the output divider exponent, the dither depth select, a 10-bit frequency trim code and a 5-bit band select. It watches oversampled copies of the clock and data lines, recognises START, repeated START and STOP, and takes part in a transfer only when the device byte matches. The device byte is a fixed 4-bit identifier followed by three selectable bits held in one of the registers. Writes carry a register pointer followed by any number of data bytes. Reads carry a pointer write, then a repeated START and a read-direction device byte. The pointer advances after every data byte in both directions.

A modelled nonvolatile image shadows the registers. A write-control bit chooses the policy. When it is clear, any transaction that wrote a register copies the whole register set into the image at its STOP. When it is set, the image changes only after a commit command: a pointer byte with no data. Writes to the device-control register always copy that byte to the image. Every copy starts a busy window of `NV_CYCLES` clocks, which stands in for the storage write time. During that window the slave acknowledges nothing.

Top module: `osc_cfg_twi_slave`

## Requirements
- R1: The slave acknowledges a device byte only when bits 7..4 equal 1011b and bits 3..1 equal the three device-select bits of the device-control register. Bit 0 is the direction (1 = read). At reset the select bits are zero, so B0h addresses a write and B1h a read. On any other device byte the slave leaves the line released and ignores the bus until the next START.
- R2: In a write, the first byte after the device byte loads the register pointer. Each later data byte is written to the register at the pointer, and the pointer then advances by one, wrapping at 8 bits. Reads advance the pointer the same way, so a burst starting at 08h covers 08h, 09h and then 0Ah.
- R3: A read is a pointer write, then a repeated START, then a read-direction device byte. The slave sends a byte most significant bit first, and sends the next byte for as long as the master acknowledges. A master NACK ends the read.
- R4: The register map and readback format are fixed. At 02h the byte reads as {111b, narrow, div[3:0]}. At 0Eh it reads as {111b, band[4:0]}. At 0Dh it reads as {1111b, wc, sel[2:0]}. Unmapped addresses read as 00h, and writes to them change nothing.
- R5: The 10-bit trim code is stored left-justified. Code bits 9..2 are the byte at 08h. Code bits 1..0 are bits 7..6 of the byte at 09h, whose bits 5..0 read as zero.
- R6: `div_log2` follows div[3:0] but saturates at 8 for any value above 8. `dither_narrow` follows the narrow bit (bit 4 of 02h).
- R7: Synchronous reset restores the factory registers: 02h = E0h, 08h = 7Dh, 09h = 00h, 0Dh = F0h, band = FACTORY_OS. With the defaults this gives a trim code of 500. Reset also sets the image to the same values.
- R8: With wc = 0, a transaction that wrote any register at 02h, 08h, 09h or 0Eh copies all five readback bytes into `nv_image` at its STOP.
- R9: With wc = 1, register writes leave `nv_image` unchanged. A pointer byte of 3Fh arms a full copy, which takes place at the next STOP.
- R10: A write to 0Dh copies that register's readback byte into `nv_image[7:0]` at the next STOP, whatever the value of wc.
- R11: Each copy starts a busy window of NV_CYCLES clocks. Inside the window every device byte is NACKed. After the window the slave responds normally.
- R12: `nv_image` holds the stored readback bytes of 02h, 08h, 09h, 0Eh and 0Dh, most significant byte first.
- R13: Address 37h is read-only. It returns {000b, FACTORY_OS}. Writing it changes no register, no output and no image byte, and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls the data line low |
| div_log2 | output | 4 | Output divider exponent, saturated at 8 |
| dither_narrow | output | 1 | Dither depth select |
| dac_code | output | 10 | Frequency trim code |
| band_sel | output | 5 | Oscillator band select |
| nv_image | output | 40 | Stored nonvolatile readback bytes |

## Verification
The bench probes the slave inside the busy window that follows each kind of copy. A design that opened the window at the wrong time, or failed to open it, would acknowledge a probe that must be refused. It checks that wc = 1 keeps the image frozen across many random writes and then copies everything on a bare 3Fh pointer. A design that committed on every write, or ignored the command, would show the wrong image bytes. Readbacks of the fixed bits, of the left-justified trim bytes, of the saturated divider and of the read-only 37h would expose a wrong mask or field position. A burst that runs into an unmapped address would expose a pointer that does not advance or wrap.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] DEV_ID     = 4'b1011;
    localparam logic [7:0] REG_DIV    = 8'h02;
    localparam logic [7:0] REG_TRIM_H = 8'h08;
    localparam logic [7:0] REG_TRIM_L = 8'h09;
    localparam logic [7:0] REG_DEVCTL = 8'h0D;
    localparam logic [7:0] REG_BAND   = 8'h0E;
    localparam logic [7:0] REG_FBAND  = 8'h37;
    localparam logic [7:0] CMD_STORE  = 8'h3F;

    typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_RACK} phase_t;
    typedef enum logic [1:0] {RK_DEV, RK_PTR, RK_DATA} rx_kind_t;

    typedef struct packed {
        logic [3:0] div;
        logic       narrow;
        logic [9:0] trim;
        logic [4:0] band;
        logic       wc;
        logic [2:0] sel;
    } cfg_t;

    function automatic cfg_t factory_cfg(input logic [4:0] os);
        cfg_t c;
        c.div    = 4'd0;
        c.narrow = 1'b0;
        c.trim   = 10'd500;
        c.band   = os;
        c.wc     = 1'b0;
        c.sel    = 3'd0;
        return c;
    endfunction

    function automatic logic [7:0] read_reg(input cfg_t c, input logic [7:0] a,
                                            input logic [4:0] os);
        logic [7:0] r;
        case (a)
            REG_DIV:    r = {3'b111, c.narrow, c.div};
            REG_TRIM_H: r = c.trim[9:2];
            REG_TRIM_L: r = {c.trim[1:0], 6'b0};
            REG_BAND:   r = {3'b111, c.band};
            REG_DEVCTL: r = {4'b1111, c.wc, c.sel};
            REG_FBAND:  r = {3'b000, os};
            default:    r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic cfg_t write_reg(input cfg_t c, input logic [7:0] a,
                                       input logic [7:0] d);
        cfg_t n;
        n = c;
        case (a)
            REG_DIV:    begin n.narrow = d[4]; n.div = d[3:0]; end
            REG_TRIM_H: n.trim[9:2] = d;
            REG_TRIM_L: n.trim[1:0] = d[7:6];
            REG_BAND:   n.band = d[4:0];
            REG_DEVCTL: begin n.wc = d[3]; n.sel = d[2:0]; end
            default:    n = c;
        endcase
        return n;
    endfunction

    function automatic logic policy_reg(input logic [7:0] a);
        return (a == REG_DIV) || (a == REG_TRIM_H) || (a == REG_TRIM_L) || (a == REG_BAND);
    endfunction

    function automatic logic [39:0] image_of(input cfg_t c, input logic [4:0] os);
        return {read_reg(c, REG_DIV, os), read_reg(c, REG_TRIM_H, os),
                read_reg(c, REG_TRIM_L, os), read_reg(c, REG_BAND, os),
                read_reg(c, REG_DEVCTL, os)};
    endfunction

    function automatic logic [3:0] sat_div(input logic [3:0] p);
        return (p > 4'd8) ? 4'd8 : p;
    endfunction
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q[0] <= scl_i;
            sda_q[0] <= sda_i;
            scl_d    <= scl_q[SYNC_STAGES-1];
            sda_d    <= sda_q[SYNC_STAGES-1];
        end
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_q[g] <= 1'b1;
                sda_q[g] <= 1'b1;
            end else begin
                scl_q[g] <= scl_q[g-1];
                sda_q[g] <= sda_q[g-1];
            end
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_s     = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
    import osc_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [2:0] dev_sel,
    input  logic       busy,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       cmd_store,
    output logic       sda_pull
);
    timeunit 1ns;
    timeprecision 1ps;

    phase_t     ph;
    rx_kind_t   kind;
    logic [3:0] bitcnt;
    logic [6:0] shreg;
    logic [7:0] txsh;
    logic       rd_mode, do_ack, more;
    logic [7:0] rx_byte;
    logic       dev_hit;

    assign rx_byte = {shreg, sda_s};
    assign dev_hit = (rx_byte[7:4] == DEV_ID) && (rx_byte[3:1] == dev_sel) && !busy;

    always_ff @(posedge clk) begin
        wr_en     <= 1'b0;
        cmd_store <= 1'b0;
        if (rst) begin
            ph      <= PH_IDLE;
            kind    <= RK_DEV;
            bitcnt  <= 4'd0;
            shreg   <= 7'd0;
            txsh    <= 8'hFF;
            ptr     <= 8'd0;
            rd_mode <= 1'b0;
            do_ack  <= 1'b0;
            more    <= 1'b0;
            wr_addr <= 8'd0;
            wr_data <= 8'd0;
        end else if (start_det) begin
            ph     <= PH_RX;
            kind   <= RK_DEV;
            bitcnt <= 4'd0;
            txsh   <= 8'hFF;
        end else if (stop_det) begin
            ph   <= PH_IDLE;
            txsh <= 8'hFF;
        end else begin
            case (ph)
                PH_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= rx_byte[6:0];
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            case (kind)
                                RK_DEV: begin
                                    do_ack  <= dev_hit;
                                    rd_mode <= rx_byte[0];
                                end
                                RK_PTR: begin
                                    do_ack    <= 1'b1;
                                    ptr       <= rx_byte;
                                    cmd_store <= (rx_byte == CMD_STORE);
                                end
                                default: begin
                                    do_ack  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_byte;
                                    ptr     <= ptr + 8'd1;
                                end
                            endcase
                        end
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        ph <= do_ack ? PH_ACK : PH_IDLE;
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= 4'd0;
                        if (kind == RK_DEV && rd_mode) begin
                            ph   <= PH_TX;
                            txsh <= rd_data;
                            ptr  <= ptr + 8'd1;
                        end else begin
                            ph   <= PH_RX;
                            kind <= (kind == RK_DEV) ? RK_PTR : RK_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            ph   <= PH_RACK;
                            txsh <= 8'hFF;
                        end else begin
                            txsh <= {txsh[6:0], 1'b1};
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        more <= !sda_s;
                    end else if (scl_fall) begin
                        if (more) begin
                            ph     <= PH_TX;
                            txsh   <= rd_data;
                            ptr    <= ptr + 8'd1;
                            bitcnt <= 4'd0;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign sda_pull = (ph == PH_ACK) || ((ph == PH_TX) && !txsh[7]);
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import osc_cfg_pkg::*;
#(
    parameter logic [4:0] FACTORY_OS = 5'd18,
    parameter int         NV_CYCLES  = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        cmd_store,
    input  logic        stop_det,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output cfg_t        cfg,
    output logic [39:0] image,
    output logic        busy
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [CW-1:0] busy_cnt;
    logic          pend_all, pend_dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= factory_cfg(FACTORY_OS);
            image    <= image_of(factory_cfg(FACTORY_OS), FACTORY_OS);
            pend_all <= 1'b0;
            pend_dev <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (wr_en) begin
                cfg <= write_reg(cfg, wr_addr, wr_data);
                if (wr_addr == REG_DEVCTL)
                    pend_dev <= 1'b1;
                else if (policy_reg(wr_addr) && !cfg.wc)
                    pend_all <= 1'b1;
            end
            if (cmd_store)
                pend_all <= 1'b1;
            if (busy_cnt != '0)
                busy_cnt <= busy_cnt - 1'b1;
            if (stop_det && (pend_all || pend_dev)) begin
                if (pend_all)
                    image <= image_of(cfg, FACTORY_OS);
                else
                    image[7:0] <= read_reg(cfg, REG_DEVCTL, FACTORY_OS);
                pend_all <= 1'b0;
                pend_dev <= 1'b0;
                busy_cnt <= CW'(NV_CYCLES);
            end
        end
    end

    assign busy    = (busy_cnt != '0);
    assign rd_data = read_reg(cfg, rd_addr, FACTORY_OS);
endmodule

// File: rtl/osc_cfg_twi_slave.sv
module osc_cfg_twi_slave
    import osc_cfg_pkg::*;
#(
    parameter logic [4:0] FACTORY_OS  = 5'd18,
    parameter int         NV_CYCLES   = 1000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull,
    output logic [3:0]  div_log2,
    output logic        dither_narrow,
    output logic [9:0]  dac_code,
    output logic [4:0]  band_sel,
    output logic [39:0] nv_image
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, wr_addr, wr_data, rd_data;
    logic       wr_en, cmd_store, nv_busy;
    cfg_t       cfg;

    twi_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_byte_engine u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .dev_sel(cfg.sel), .busy(nv_busy),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_store(cmd_store), .sda_pull(sda_pull)
    );

    cfg_store #(.FACTORY_OS(FACTORY_OS), .NV_CYCLES(NV_CYCLES)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_store(cmd_store), .stop_det(stop_det), .rd_addr(ptr), .rd_data(rd_data),
        .cfg(cfg), .image(nv_image), .busy(nv_busy)
    );

    assign div_log2      = sat_div(cfg.div);
    assign dither_narrow = cfg.narrow;
    assign dac_code      = cfg.trim;
    assign band_sel      = cfg.band;
endmodule

// File: rtl/osc_cfg_twi_chk.sv
module osc_cfg_twi_chk (
    input logic        clk,
    input logic        rst,
    input logic        sda_pull,
    input logic        scl_s,
    input logic        stop_det,
    input logic        busy,
    input logic [39:0] nv_image,
    input logic [3:0]  div_log2
);
    timeunit 1ns;
    timeprecision 1ps;

    a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    a_r11_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det));

    a_r8_image_after_stop: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv_image) |-> $past(stop_det));

    a_r1_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_s);

    a_r6_div_saturates: assert property (@(posedge clk) disable iff (rst)
        div_log2 <= 4'd8);
endmodule

bind osc_cfg_twi_slave osc_cfg_twi_chk u_chk (
    .clk(clk), .rst(rst), .sda_pull(sda_pull), .scl_s(scl_s), .stop_det(stop_det),
    .busy(nv_busy), .nv_image(nv_image), .div_log2(div_log2)
);

// File: tb/sim_osc_cfg_twi_slave.sv
module sim_osc_cfg_twi_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NVC = 1000;
    localparam int H   = 8;
    localparam logic [4:0] OS = 5'd18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull, dither_narrow;
    logic [3:0] div_log2;
    logic [9:0] dac_code;
    logic [4:0] band_sel;
    logic [39:0] nv_image;
    wire sda_line = m_sda & ~sda_pull;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] rb [4];
    logic [7:0] mp, mh, ml, mo, md;
    logic [39:0] nimg;

    always #10 clk = ~clk;

    osc_cfg_twi_slave #(.FACTORY_OS(OS), .NV_CYCLES(NVC)) u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_pull(sda_pull),
        .div_log2(div_log2), .dither_narrow(dither_narrow), .dac_code(dac_code),
        .band_sel(band_sel), .nv_image(nv_image)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic t_start();
        m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
    endtask

    task automatic t_stop();
        m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
    endtask

    task automatic t_bit(input logic v, output logic seen);
        m_sda = v; hw(); m_scl = 1'b1; hw(); seen = sda_line; hw(); m_scl = 1'b0; hw();
    endtask

    task automatic t_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) t_bit(b[i], s);
        t_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic t_rbyte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            t_bit(1'b1, s);
            b[i] = s;
        end
        t_bit(!mack, s);
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, output logic ok);
        logic a;
        t_start();
        t_wbyte(dev, a);
        ok = a;
        if (a) begin
            t_wbyte(ptr, a); ok &= a;
            if (n > 0) begin t_wbyte(d0, a); ok &= a; end
            if (n > 1) begin t_wbyte(d1, a); ok &= a; end
        end
        t_stop();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] ptr, input int n,
                           output logic ok);
        logic a;
        t_start();
        t_wbyte(dev & 8'hFE, a);
        ok = a;
        if (a) begin
            t_wbyte(ptr, a); ok &= a;
            t_start();
            t_wbyte(dev | 8'h01, a); ok &= a;
            if (a) for (int i = 0; i < n; i++) t_rbyte(i < n - 1, rb[i]);
        end
        t_stop();
    endtask

    task automatic probe(input logic [7:0] dev, output logic ok);
        t_start();
        t_wbyte(dev, ok);
        t_stop();
    endtask

    task automatic model_reset();
        mp = 8'hE0; mh = 8'h7D; ml = 8'h00; mo = {3'b111, OS}; md = 8'hF0;
        nimg = {mp, mh, ml, mo, md};
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h02: mp = {3'b111, d[4:0]};
            8'h08: mh = d;
            8'h09: ml = {d[7:6], 6'b0};
            8'h0E: mo = {3'b111, d[4:0]};
            8'h0D: md = {4'hF, d[3:0]};
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h02: return mp;
            8'h08: return mh;
            8'h09: return ml;
            8'h0E: return mo;
            8'h0D: return md;
            8'h37: return {3'b000, OS};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] exp_div();
        return (mp[3:0] > 4'd8) ? 4'd8 : mp[3:0];
    endfunction

    task automatic chk_outputs(input string tag);
        chk({tag, " trim"}, {30'd0, dac_code}, {30'd0, mh, ml[7:6]});
        chk({tag, " band"}, {35'd0, band_sel}, {35'd0, mo[4:0]});
        chk({tag, " div"}, {36'd0, div_log2}, {36'd0, exp_div()});
        chk({tag, " narrow"}, {39'd0, dither_narrow}, {39'd0, mp[4]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ok;
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        model_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R7 R12: reset state
        chk_outputs("R7 reset");
        chk("R7 trim 500", {30'd0, dac_code}, 40'd500);
        chk("R12 reset image", nv_image, nimg);

        // R3 R4: single reads
        do_read(8'hB0, 8'h02, 1, ok);
        chk("R3 read ack", {39'd0, ok}, 40'd1);
        chk("R4 read 02h", {32'd0, rb[0]}, 40'hE0);
        do_read(8'hB0, 8'h0D, 1, ok);
        chk("R4 read 0Dh", {32'd0, rb[0]}, 40'hF0);
        do_read(8'hB0, 8'h0E, 1, ok);
        chk("R4 read 0Eh", {32'd0, rb[0]}, {32'd0, mo});
        do_read(8'hB0, 8'h37, 1, ok);
        chk("R13 read 37h", {32'd0, rb[0]}, {35'd0, OS});
        // R2 R5: burst read
        do_read(8'hB0, 8'h08, 2, ok);
        chk("R2 burst 08h", {32'd0, rb[0]}, 40'h7D);
        chk("R5 burst 09h", {32'd0, rb[1]}, 40'h00);

        // R1: device byte matching
        probe(8'hB2, ok);
        chk("R1 wrong select nack", {39'd0, ok}, 40'd0);
        probe(8'h30, ok);
        chk("R1 wrong id nack", {39'd0, ok}, 40'd0);
        probe(8'hB0, ok);
        chk("R1 match ack", {39'd0, ok}, 40'd1);

        // R5 R8 R11: auto commit with wc=0
        do_write(8'hB0, 8'h08, 2, 8'hA3, 8'hC0, ok);
        model_write(8'h08, 8'hA3); model_write(8'h09, 8'hC0);
        nimg = {mp, mh, ml, mo, md};
        chk("R2 burst write ack", {39'd0, ok}, 40'd1);
        chk("R5 trim 655", {30'd0, dac_code}, 40'd655);
        chk("R8 auto image", nv_image, nimg);
        probe(8'hB0, ok);
        chk("R11 busy nack", {39'd0, ok}, 40'd0);
        repeat (NVC + 50) @(negedge clk);
        probe(8'hB0, ok);
        chk("R11 after busy ack", {39'd0, ok}, 40'd1);

        // R6: saturation and narrow bit
        do_write(8'hB0, 8'h02, 1, 8'h1B, 8'h00, ok);
        model_write(8'h02, 8'h1B);
        nimg = {mp, mh, ml, mo, md};
        chk_outputs("R6 div sat");
        chk("R6 div is 8", {36'd0, div_log2}, 40'd8);
        repeat (NVC + 50) @(negedge clk);
        do_read(8'hB0, 8'h02, 1, ok);
        chk("R4 readback FBh", {32'd0, rb[0]}, 40'hFB);

        // R5: low trim byte masks
        do_write(8'hB0, 8'h09, 1, 8'hFF, 8'h00, ok);
        model_write(8'h09, 8'hFF);
        nimg = {mp, mh, ml, mo, md};
        repeat (NVC + 50) @(negedge clk);
        do_read(8'hB0, 8'h09, 1, ok);
        chk("R5 low byte zeros", {32'd0, rb[0]}, 40'hC0);
        chk("R8 image after low write", nv_image, nimg);

        // R13: read-only range byte
        do_write(8'hB0, 8'h37, 1, 8'h55, 8'h00, ok);
        chk_outputs("R13 write ignored");
        chk("R13 image unchanged", nv_image, nimg);
        probe(8'hB0, ok);
        chk("R13 no busy", {39'd0, ok}, 40'd1);
        do_read(8'hB0, 8'h37, 1, ok);
        chk("R13 still factory", {32'd0, rb[0]}, {35'd0, OS});

        // R10 R1: device-control write, wc=1, select=3
        do_write(8'hB0, 8'h0D, 1, 8'h0B, 8'h00, ok);
        model_write(8'h0D, 8'h0B);
        nimg[7:0] = md;
        chk("R10 dev byte stored", nv_image, nimg);
        repeat (NVC + 50) @(negedge clk);
        probe(8'hB0, ok);
        chk("R1 old select nack", {39'd0, ok}, 40'd0);
        probe(8'hB6, ok);
        chk("R1 new select ack", {39'd0, ok}, 40'd1);

        // R9: wc=1 holds image, command commits
        do_write(8'hB6, 8'h0E, 1, 8'h10, 8'h00, ok);
        model_write(8'h0E, 8'h10);
        chk_outputs("R9 band write");
        chk("R9 image frozen", nv_image, nimg);
        probe(8'hB6, ok);
        chk("R9 no busy", {39'd0, ok}, 40'd1);
        do_write(8'hB6, 8'h3F, 0, 8'h00, 8'h00, ok);
        nimg = {mp, mh, ml, mo, md};
        chk("R9 commit image", nv_image, nimg);
        probe(8'hB6, ok);
        chk("R11 commit busy nack", {39'd0, ok}, 40'd0);
        repeat (NVC + 50) @(negedge clk);

        // R4 R2 R9: random writes with wc=1
        for (int k = 0; k < 20; k++) begin
            logic [7:0] a, d;
            logic [2:0] pick;
            pick = 3'($urandom % 6);
            case (pick)
                3'd0: a = 8'h02;
                3'd1: a = 8'h08;
                3'd2: a = 8'h09;
                3'd3: a = 8'h0E;
                3'd4: a = 8'h37;
                default: a = 8'h2A;
            endcase
            d = 8'($urandom);
            do_write(8'hB6, a, 1, d, 8'h00, ok);
            model_write(a, d);
            do_read(8'hB6, a, 1, ok);
            chk("R4 random readback", {32'd0, rb[0]}, {32'd0, model_read(a)});
            chk_outputs("R6 random outputs");
        end
        chk("R9 image after random", nv_image, nimg);

        // R2: burst read wraps into unmapped 0Ah
        do_read(8'hB6, 8'h08, 3, ok);
        chk("R2 burst first", {32'd0, rb[0]}, {32'd0, mh});
        chk("R2 burst second", {32'd0, rb[1]}, {32'd0, ml});
        chk("R4 unmapped 0Ah", {32'd0, rb[2]}, 40'h00);

        // R7: reset restores factory state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        repeat (5) @(negedge clk);
        chk_outputs("R7 second reset");
        chk("R7 image after reset", nv_image, nimg);
        probe(8'hB0, ok);
        chk("R7 select zero ack", {39'd0, ok}, 40'd1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule